// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block controls 32 general-purpose pins from a simple register bus. The pins form two banks of 16. The low bank holds pins 0 to 15 and the high bank holds pins 16 to 31. The high bank sits 0x80 above the low bank and has the same register layout. Each per-pin feature has one 32-bit register per bank. A single write sets some pin bits and clears others, so software never needs a read-modify-write sequence: the low half of the write data carries the set bits and the high half carries the clear bits.

The per-pin features are:
- output value
- output enable
- input enable
- two alternate output selects
- one alternate input select

The pad side drives an output vector and an output-enable vector, receives the pad input vector, and takes the outputs of two alternate functions. The pad inputs pass through a two-flop synchronizer. The synchronized value feeds three things: a readback register, rising-edge and falling-edge status flags that software clears by writing ones, and a forwarded input for the alternate input function. Pins 23, 29, 30 and 31 do not exist. They always read as zero.

Top module: `gpio_atomic_bank`

## Requirements
- R1: A write to a feature register with data bit n = 1 (n in 0..15) sets that feature for pin n of the addressed bank. The feature registers and their bank offsets are: output value at 0x00, output enable at 0x04, input enable at 0x08, alternate output 1 select at 0x0C, alternate output 2 select at 0x10, and alternate input select at 0x14.
- R2: In the same write, data bit n+16 = 1 clears the feature for pin n. A data bit of 0 in either half leaves that pin's bit unchanged.
- R3: When the set bit and the clear bit for the same pin are both 1 in one write, the bit ends up cleared.
- R4: Bus address bit 7 selects the bank: 0 for pins 0..15, 1 for pins 16..31. Pin 16+k appears at bit k of the high-bank registers. A write to one bank never changes the other bank.
- R5: A read of a word-aligned register returns that bank's 16 pin bits in data bits 15:0, with bits 31:16 zero. Registers are independent of each other. An unmapped offset reads zero.
- R6: The readback register at offset 0x18 returns the pad input ANDed with input enable. Its latency is two clocks, because of the synchronizer. Writes to it are ignored.
- R7: The rising-edge status (offset 0x1C) and falling-edge status (offset 0x20) latch a 1 when the synchronized input of an input-enabled pin changes in that direction. A flag stays set until it is cleared. If a new edge arrives in the same cycle as a clear, the edge wins.
- R8: Writing 1 to bit n of an edge status register clears pin n's flag. Bits 31:16 of that write are ignored.
- R9: The reserved pins 23, 29, 30 and 31 read 0 in every register, never assert output enable, and ignore writes.
- R10: Output enable for a pin comes from its output-enable bit. A pin whose output enable is 0 drives 0 on its output.
- R11: While output is enabled, an active alternate output 1 select drives that function's output onto the pin. Alternate output 1 takes priority over alternate output 2. With neither select active, the output value bit drives the pin.
- R12: The alternate input data bit for a pin equals the synchronized pad input ANDed with that pin's input enable and alternate input select.
- R13: After reset, every register reads 0 and no pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address: bit 7 is the bank, bits 6:2 are the register |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data: set bits in 15:0, clear bits in 31:16 |
| busRdData | output | 32 | Combinational read data for busAddr |
| padIn | input | 32 | Raw pad input levels |
| padOut | output | 32 | Pad output drive |
| padOe | output | 32 | Pad output enable |
| altOut1In | input | 32 | Alternate function 1 output values |
| altOut2In | input | 32 | Alternate function 2 output values |
| altInData | output | 32 | Synchronized input forwarded to the alternate input function |

## Verification
The bench targets the following corner cases:
- A write that sets and clears the same pin. A design with set priority would leave that bit at 1.
- Writes to the high bank, checked against the low bank. A mis-decoded bank bit would corrupt pins 0..15.
- A clear written into the high half of an edge status register. A design that applied the set/clear scheme there would drop a pending edge.
- Reserved pins. A missing mask would show up as ones at bit 7 or bits 15:13 of high-bank reads.
- Readback latency and the pad multiplexer priority. A synchronizer one stage short shows the pad a clock early. Swapped alternate-output priority drives the wrong function.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

  // Feature register word indices (byte offset = index * 4)
  localparam int NUM_FEAT  = 6;
  localparam int F_OUTVAL  = 0;
  localparam int F_OUTEN   = 1;
  localparam int F_INEN    = 2;
  localparam int F_ALTO1   = 3;
  localparam int F_ALTO2   = 4;
  localparam int F_ALTI    = 5;
  localparam int W_RDBACK  = 6;
  localparam int W_POSEDGE = 7;
  localparam int W_NEGEDGE = 8;
  localparam int LAST_WORD = 8;

  localparam int BANK_SEL_W = 4;

  typedef struct packed {
    logic [NUM_FEAT-1:0]   featWr;
    logic                  posClr;
    logic                  negClr;
    logic [BANK_SEL_W-1:0] bankSel;
    logic [3:0]            rdSel;
    logic                  rdValid;
  } ctrl_strobe_t;

endpackage

// File: rtl/gpio_atomic_ctrl.sv
module gpio_atomic_ctrl
  import gpio_atomic_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BANK_SHIFT = 7,
  parameter int NUM_BANKS  = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrl_strobe_t      strobe
);

  localparam int WORD_W = BANK_SHIFT - 2;
  localparam int BIDX_W = ADDR_W - BANK_SHIFT;

  logic [WORD_W-1:0] wordIdx;
  logic [BIDX_W-1:0] bankIdx;
  logic              inRange;

  always_comb begin
    wordIdx = busAddr[BANK_SHIFT-1:2];
    bankIdx = busAddr[ADDR_W-1:BANK_SHIFT];
    inRange = (int'(bankIdx) < NUM_BANKS) && (busAddr[1:0] == 2'b00);

    strobe         = '0;
    strobe.bankSel = BANK_SEL_W'(bankIdx);
    strobe.rdSel   = 4'(wordIdx);
    strobe.rdValid = inRange && (int'(wordIdx) <= LAST_WORD);

    for (int f = 0; f < NUM_FEAT; f++) begin
      strobe.featWr[f] = busWrEn && inRange && (int'(wordIdx) == f);
    end
    strobe.posClr = busWrEn && inRange && (int'(wordIdx) == W_POSEDGE);
    strobe.negClr = busWrEn && inRange && (int'(wordIdx) == W_NEGEDGE);
  end

endmodule

// File: rtl/gpio_atomic_datapath.sv
module gpio_atomic_datapath
  import gpio_atomic_pkg::*;
#(
  parameter int          NUM_PINS  = 32,
  parameter int          BANK_W    = 16,
  parameter logic [31:0] RSVD_MASK = 32'hE080_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_strobe_t          strobe,
  input  logic [2*BANK_W-1:0]   busWrData,
  output logic [2*BANK_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  input  logic [NUM_PINS-1:0]   altOut1In,
  input  logic [NUM_PINS-1:0]   altOut2In,
  output logic [NUM_PINS-1:0]   altInData
);

  localparam int NUM_BANKS = NUM_PINS / BANK_W;
  localparam logic [NUM_PINS-1:0] LIVE = ~RSVD_MASK[NUM_PINS-1:0];

  logic [BANK_W-1:0] setBits, clrBits;
  assign setBits = busWrData[BANK_W-1:0];
  assign clrBits = busWrData[2*BANK_W-1:BANK_W];

  // Feature registers
  logic [NUM_FEAT-1:0][NUM_PINS-1:0] featQ, featD;

  always_comb begin
    featD = featQ;
    for (int f = 0; f < NUM_FEAT; f++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe.featWr[f] && int'(strobe.bankSel) == b) begin
          featD[f][b*BANK_W +: BANK_W] =
            (featQ[f][b*BANK_W +: BANK_W] | setBits) & ~clrBits;
        end
      end
      featD[f] = featD[f] & LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) featQ <= '0;
    else        featQ <= featD;
  end

  // Input synchronizer and previous sample
  logic [NUM_PINS-1:0] syncA, syncB, prevQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  logic [NUM_PINS-1:0] inEn, readBack, riseEv, fallEv;
  assign inEn     = featQ[F_INEN];
  assign readBack = syncB & inEn & LIVE;
  assign riseEv   = syncB & ~prevQ & inEn & LIVE;
  assign fallEv   = ~syncB & prevQ & inEn & LIVE;

  // Edge status, write-one-to-clear from the low half
  logic [NUM_PINS-1:0] posQ, negQ, posClrMask, negClrMask;

  always_comb begin
    posClrMask = '0;
    negClrMask = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(strobe.bankSel) == b) begin
        if (strobe.posClr) posClrMask[b*BANK_W +: BANK_W] = setBits;
        if (strobe.negClr) negClrMask[b*BANK_W +: BANK_W] = setBits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posQ <= '0;
      negQ <= '0;
    end else begin
      posQ <= (posQ & ~posClrMask) | riseEv;
      negQ <= (negQ & ~negClrMask) | fallEv;
    end
  end

  // Pad output multiplexer
  logic [NUM_PINS-1:0] a1Sel, a2Sel, drive;
  assign a1Sel  = featQ[F_ALTO1];
  assign a2Sel  = featQ[F_ALTO2];
  assign drive  = (a1Sel & altOut1In)
                | (~a1Sel & a2Sel & altOut2In)
                | (~a1Sel & ~a2Sel & featQ[F_OUTVAL]);
  assign padOe  = featQ[F_OUTEN];
  assign padOut = drive & padOe;
  assign altInData = syncB & inEn & featQ[F_ALTI];

  // Read multiplexer
  logic [NUM_PINS-1:0] rdVec;
  logic [BANK_W-1:0]   rdBank;

  always_comb begin
    case (int'(strobe.rdSel))
      F_OUTVAL, F_OUTEN, F_INEN, F_ALTO1, F_ALTO2, F_ALTI:
                 rdVec = featQ[strobe.rdSel[2:0]];
      W_RDBACK:  rdVec = readBack;
      W_POSEDGE: rdVec = posQ;
      W_NEGEDGE: rdVec = negQ;
      default:   rdVec = '0;
    endcase
    rdBank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(strobe.bankSel) == b) rdBank = rdVec[b*BANK_W +: BANK_W];
    end
    busRdData = strobe.rdValid ? {{BANK_W{1'b0}}, rdBank} : '0;
  end

endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
  import gpio_atomic_pkg::*;
#(
  parameter int          NUM_PINS   = 32,
  parameter int          BANK_W     = 16,
  parameter int          ADDR_W     = 8,
  parameter int          BANK_SHIFT = 7,
  parameter logic [31:0] RSVD_MASK  = 32'hE080_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [2*BANK_W-1:0] busWrData,
  output logic [2*BANK_W-1:0] busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_PINS-1:0] altOut1In,
  input  logic [NUM_PINS-1:0] altOut2In,
  output logic [NUM_PINS-1:0] altInData
);

  localparam int NUM_BANKS = NUM_PINS / BANK_W;

  ctrl_strobe_t strobe;

  gpio_atomic_ctrl #(
    .ADDR_W    (ADDR_W),
    .BANK_SHIFT(BANK_SHIFT),
    .NUM_BANKS (NUM_BANKS)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_atomic_datapath #(
    .NUM_PINS (NUM_PINS),
    .BANK_W   (BANK_W),
    .RSVD_MASK(RSVD_MASK)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .altOut1In(altOut1In),
    .altOut2In(altOut2In),
    .altInData(altInData)
  );

endmodule

// File: rtl/gpio_atomic_chk.sv
module gpio_atomic_chk #(
  parameter int          NUM_PINS   = 32,
  parameter int          ADDR_W     = 8,
  parameter int          BANK_SHIFT = 7,
  parameter logic [31:0] RSVD_MASK  = 32'hE080_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic                wrSet0,
  input logic                wrClr0,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut
);

  localparam logic [ADDR_W-1:0] OE_LOW = ADDR_W'(4);
  localparam logic [BANK_SHIFT-1:0] OE_OFS = BANK_SHIFT'(4);

  // R1
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == OE_LOW && wrSet0 && !wrClr0) |=> padOe[0]);

  // R3
  oe_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == OE_LOW && wrClr0) |=> !padOe[0]);

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWrEn && busAddr[BANK_SHIFT-1:0] == OE_OFS) |=> $stable(padOe));

  // R9
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (padOe & RSVD_MASK[NUM_PINS-1:0]) == '0);

  // R10
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (padOut & ~padOe) == '0);

endmodule

bind gpio_atomic_bank gpio_atomic_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .BANK_SHIFT(BANK_SHIFT),
  .RSVD_MASK (RSVD_MASK)
) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busAddr(busAddr),
  .busWrEn(busWrEn),
  .wrSet0 (busWrData[0]),
  .wrClr0 (busWrData[BANK_W]),
  .padOe  (padOe),
  .padOut (padOut)
);

// File: tb/test_gpio_atomic_bank.sv
module test_gpio_atomic_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, altInData;
  logic [31:0] altOut1In = '0;
  logic [31:0] altOut2In = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_atomic_bank i_gpio_atomic_bank (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .altOut1In(altOut1In),
    .altOut2In(altOut2In), .altInData(altInData)
  );

  // {write?, write addr, write data, read addr, expected read}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF}, // R1 set
    {1'b1, 8'h00, 32'h000F_0000, 8'h00, 32'h0000_00F0}, // R2 clear
    {1'b1, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_00F0}, // R2 zero data
    {1'b1, 8'h00, 32'h0010_0011, 8'h00, 32'h0000_00E1}, // R3 clear wins
    {1'b1, 8'h80, 32'h0000_FFFF, 8'h80, 32'h0000_1F7F}, // R9 high bank
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_00E1}, // R4 low untouched
    {1'b1, 8'h04, 32'h0000_A5A5, 8'h04, 32'h0000_A5A5}, // R5
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_00E1}, // R5 independent
    {1'b1, 8'h84, 32'h0000_0003, 8'h84, 32'h0000_0003}, // R4
    {1'b1, 8'h18, 32'h0000_FFFF, 8'h18, 32'h0000_0000}, // R6 ignored
    {1'b1, 8'h0C, 32'h0000_0001, 8'h0C, 32'h0000_0001}, // R5
    {1'b1, 8'h14, 32'h0000_0005, 8'h14, 32'h0000_0005}, // R5
    {1'b0, 8'h00, 32'h0000_0000, 8'h3C, 32'h0000_0000}  // R5 unmapped
  };

  localparam string VREQ [NVEC] = '{"R1", "R2", "R2", "R3", "R9", "R4",
    "R5", "R5", "R4", "R6", "R5", "R5", "R5"};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R13 reset state
    for (int w = 0; w < 9; w++) begin
      rd(8'(w * 4), r);        check("R13", r, 32'h0);
      rd(8'(w * 4 + 128), r);  check("R13", r, 32'h0);
    end
    #1; check("R13", padOe, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][80]) wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], r);
      check(VREQ[i], r, VEC[i][31:0]);
    end

    do_reset();

    // R10 pad drive
    wr(8'h00, 32'h4);
    #1; check("R10", padOut, 32'h0); check("R10", padOe, 32'h0);
    wr(8'h04, 32'h4);
    #1; check("R10", padOe, 32'h4); check("R10", padOut, 32'h4);

    // R11 alternate output priority
    altOut1In = 32'h0; altOut2In = 32'hFFFF_FFFF;
    wr(8'h0C, 32'h4);
    #1; check("R11", padOut, 32'h0);
    wr(8'h10, 32'h4);
    #1; check("R11", padOut, 32'h0);
    wr(8'h0C, 32'h0004_0000);
    #1; check("R11", padOut, 32'h4);

    // R6 readback latency
    wr(8'h08, 32'h20);
    wr(8'h88, 32'h10);
    padIn = 32'h0010_0060;
    @(posedge clk); #1;
    rd(8'h18, r); check("R6", r, 32'h0);
    @(posedge clk); #1;
    rd(8'h18, r); check("R6", r, 32'h20);
    rd(8'h98, r); check("R6", r, 32'h10);

    // R7 rising edge
    repeat (3) @(posedge clk); #1;
    rd(8'h1C, r); check("R7", r, 32'h20);
    rd(8'h9C, r); check("R7", r, 32'h10);
    rd(8'h20, r); check("R7", r, 32'h0);

    // R8 write-one-to-clear
    wr(8'h1C, 32'h0020_0000);
    rd(8'h1C, r); check("R8", r, 32'h20);
    wr(8'h1C, 32'h0000_0020);
    rd(8'h1C, r); check("R8", r, 32'h0);
    rd(8'h9C, r); check("R8", r, 32'h10);

    // R7 falling edge
    @(negedge clk); padIn = 32'h0010_0040;
    repeat (4) @(posedge clk); #1;
    rd(8'h20, r); check("R7", r, 32'h20);
    rd(8'h1C, r); check("R7", r, 32'h0);

    // R12 alternate input
    wr(8'h14, 32'h60);
    wr(8'h94, 32'h10);
    #1; check("R12", altInData, 32'h0010_0000);

    // R9 reserved pins
    wr(8'h84, 32'h0000_FFFF);
    #1; check("R9", padOe & 32'hE080_0000, 32'h0);
    wr(8'h88, 32'h0000_FFFF);
    @(negedge clk); padIn = 32'hFFFF_FFFF;
    repeat (4) @(posedge clk); #1;
    rd(8'h98, r); check("R9", r, 32'h0000_1F7F);
    rd(8'h9C, r); check("R9", r, 32'h0000_1F7F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule